// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches both access ports. Each port presents an active-low chip select, an address and an active-low write strobe. When both ports are selected and point at the same location, the block flags the port whose request settled later as busy. It pulls that port's active-low busy line low and suppresses its write toward the array. The other port keeps full access. Requests are registered once per clock. A request counts as "settled" in the cycle where its registered select or address last changed.

A mode input picks one of two behaviours. In master mode the block decides priority itself and drives the busy outputs. In slave mode the busy outputs rest high and the block makes no decisions of its own. Instead, externally supplied active-low busy inputs inhibit the writes of their ports. This lets a second arbiter share one decision across devices.

Priority is held in a three-state machine:
- `ARB_FREE`: no collision is owned.
- `ARB_LEFT_HOLD`: left owns the location and right is busy.
- `ARB_RIGHT_HOLD`: right owns the location and left is busy.

The transitions are:
- GRANT_LEFT (`ARB_FREE` to `ARB_LEFT_HOLD`): a collision appears with right settling later, or both settling in the same cycle.
- GRANT_RIGHT (`ARB_FREE` to `ARB_RIGHT_HOLD`): a collision appears with only left settling later.
- KEEP (a hold state to itself): the collision persists.
- RELEASE (a hold state to `ARB_FREE`): the collision ends, or slave mode is selected.

Top module: `dpca_top`

## Requirements
- R1: In master mode, when both ports are selected at different registered addresses, both busy outputs are high, and each port's write passes through.
- R2: When the registered addresses match but either chip select (active low) is high, both busy outputs are high.
- R3: When both ports are selected at the same address, exactly one busy output is low, and it belongs to the port whose select or address changed later. Inputs applied before clock edge k show their effect on busy and on write-pass in the cycle after edge k.
- R4: If both ports change into the same collision in the same cycle, the right port is flagged busy and left wins.
- R5: The two busy outputs are never low at the same time.
- R6: A port's write-pass output is high only when that port is selected, its write strobe (active low) is low, and its own busy is not asserted. This holds in the same cycle that busy is low.
- R7: A port that won a collision keeps priority while the collision persists, even if both ports move together to a new common address.
- R8: When the collision ends, busy returns high in the cycle after the edge that registers the change.
- R9: In slave mode (mode input = 1) both busy outputs are high. A low busy input blocks the write of its own port only.
- R10: A synchronous active-high reset clears priority state and the registered requests, so both busy outputs are high and both write-pass outputs are low after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_slave | input | 1 | 0 = master (local arbitration), 1 = slave (external inhibit) |
| lt_cs_n | input | 1 | Left chip select, active low |
| lt_we_n | input | 1 | Left write strobe, active low |
| lt_addr | input | 13 | Left address |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_we_n | input | 1 | Right write strobe, active low |
| rt_addr | input | 13 | Right address |
| lt_busy_n_i | input | 1 | Left external busy, active low, used in slave mode |
| rt_busy_n_i | input | 1 | Right external busy, active low, used in slave mode |
| lt_busy_n_o | output | 1 | Left busy flag, active low |
| rt_busy_n_o | output | 1 | Right busy flag, active low |
| lt_wr_ok | output | 1 | Left write allowed toward the array |
| rt_wr_ok | output | 1 | Right write allowed toward the array |

## Verification
Two functions can fall in the same cycle. One is the grant of a fresh collision. The other is the write suppression of the losing port, which must already be in force in the very cycle the collision is first registered. The bench provokes this by applying a matching write on one port one cycle after the other port settled. It also applies matching writes on both ports in the same cycle. In each case it reads the busy outputs and the write-pass outputs together in the first cycle after the edge. It judges that the later port, or the right port on a tie, is both busy and blocked, while the winner still writes.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_HOLD  = 2'd1,
        ARB_RIGHT_HOLD = 2'd2
    } arb_state_t;

    // Decision for a fresh collision: the later-settling port loses,
    // a same-cycle tie goes to the left port.
    function automatic arb_state_t fresh_owner(input logic lt_moved, input logic rt_moved);
        if (lt_moved && !rt_moved) begin
            return ARB_RIGHT_HOLD;
        end
        return ARB_LEFT_HOLD;
    endfunction
endpackage

// File: rtl/dpca_port_stage.sv
module dpca_port_stage #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          sel_q,
    output logic          wr_q,
    output logic [AW-1:0] addr_q,
    output logic          moved
);
    logic          sel_p;
    logic [AW-1:0] addr_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            sel_p  <= 1'b0;
            addr_p <= '0;
        end else begin
            sel_q  <= ~cs_n;
            wr_q   <= ~we_n;
            addr_q <= addr;
            sel_p  <= sel_q;
            addr_p <= addr_q;
        end
    end

    // Request settled in this cycle: select or address differs from last cycle
    always_comb begin
        moved = (sel_q != sel_p) || (addr_q != addr_p);
    end
endmodule

// File: rtl/dpca_collide_fsm.sv
module dpca_collide_fsm
    import dpca_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_slave,
    input  logic          lt_sel,
    input  logic [AW-1:0] lt_addr,
    input  logic          lt_moved,
    input  logic          rt_sel,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_moved,
    output logic          hit,
    output logic          lt_flag,
    output logic          rt_flag
);
    arb_state_t state_q, state_d, owner;

    always_comb begin
        hit = lt_sel && rt_sel && (lt_addr == rt_addr);
    end

    always_comb begin
        state_d = state_q;
        if (mode_slave) begin
            state_d = ARB_FREE;
        end else begin
            unique case (state_q)
                ARB_FREE: begin
                    if (hit) begin
                        state_d = fresh_owner(lt_moved, rt_moved);
                    end
                end
                ARB_LEFT_HOLD, ARB_RIGHT_HOLD: begin
                    if (!hit) begin
                        state_d = ARB_FREE;
                    end
                end
                default: state_d = ARB_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: a held owner keeps priority, a fresh collision is decided now
    always_comb begin
        owner   = (state_q == ARB_FREE) ? fresh_owner(lt_moved, rt_moved) : state_q;
        lt_flag = 1'b0;
        rt_flag = 1'b0;
        if (!mode_slave && hit) begin
            unique case (owner)
                ARB_LEFT_HOLD:  rt_flag = 1'b1;
                ARB_RIGHT_HOLD: lt_flag = 1'b1;
                default: begin
                    lt_flag = 1'b0;
                    rt_flag = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dpca_wr_gate.sv
module dpca_wr_gate (
    input  logic mode_slave,
    input  logic sel,
    input  logic wr,
    input  logic local_busy,
    input  logic ext_busy_n,
    output logic busy_n_o,
    output logic wr_ok
);
    logic blocked;

    always_comb begin
        blocked  = mode_slave ? ~ext_busy_n : local_busy;
        busy_n_o = mode_slave ? 1'b1 : ~local_busy;
        wr_ok    = sel && wr && !blocked;
    end
endmodule

// File: rtl/dpca_top.sv
module dpca_top #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_slave,
    input  logic          lt_cs_n,
    input  logic          lt_we_n,
    input  logic [AW-1:0] lt_addr,
    input  logic          rt_cs_n,
    input  logic          rt_we_n,
    input  logic [AW-1:0] rt_addr,
    input  logic          lt_busy_n_i,
    input  logic          rt_busy_n_i,
    output logic          lt_busy_n_o,
    output logic          rt_busy_n_o,
    output logic          lt_wr_ok,
    output logic          rt_wr_ok
);
    logic          l_sel, l_wr, l_moved;
    logic          r_sel, r_wr, r_moved;
    logic [AW-1:0] l_addr, r_addr;
    logic          hit, lt_flag, rt_flag;

    dpca_port_stage #(.AW(AW)) u_lt_stage (
        .clk(clk), .rst(rst), .cs_n(lt_cs_n), .we_n(lt_we_n), .addr(lt_addr),
        .sel_q(l_sel), .wr_q(l_wr), .addr_q(l_addr), .moved(l_moved)
    );

    dpca_port_stage #(.AW(AW)) u_rt_stage (
        .clk(clk), .rst(rst), .cs_n(rt_cs_n), .we_n(rt_we_n), .addr(rt_addr),
        .sel_q(r_sel), .wr_q(r_wr), .addr_q(r_addr), .moved(r_moved)
    );

    dpca_collide_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .mode_slave(mode_slave),
        .lt_sel(l_sel), .lt_addr(l_addr), .lt_moved(l_moved),
        .rt_sel(r_sel), .rt_addr(r_addr), .rt_moved(r_moved),
        .hit(hit), .lt_flag(lt_flag), .rt_flag(rt_flag)
    );

    dpca_wr_gate u_lt_gate (
        .mode_slave(mode_slave), .sel(l_sel), .wr(l_wr), .local_busy(lt_flag),
        .ext_busy_n(lt_busy_n_i), .busy_n_o(lt_busy_n_o), .wr_ok(lt_wr_ok)
    );

    dpca_wr_gate u_rt_gate (
        .mode_slave(mode_slave), .sel(r_sel), .wr(r_wr), .local_busy(rt_flag),
        .ext_busy_n(rt_busy_n_i), .busy_n_o(rt_busy_n_o), .wr_ok(rt_wr_ok)
    );
endmodule

// File: rtl/dpca_checker.sv
module dpca_checker (
    input logic clk,
    input logic rst,
    input logic mode_slave,
    input logic hit,
    input logic lt_busy_n_i,
    input logic rt_busy_n_i,
    input logic lt_busy_n_o,
    input logic rt_busy_n_o,
    input logic lt_wr_ok,
    input logic rt_wr_ok
);
    // R1 R2
    no_hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (lt_busy_n_o && rt_busy_n_o));

    // R3
    one_busy_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !mode_slave) |-> (lt_busy_n_o != rt_busy_n_o));

    // R5
    never_both_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(!lt_busy_n_o && !rt_busy_n_o));

    // R6
    lt_busy_blocks_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !lt_busy_n_o |-> !lt_wr_ok);

    // R6
    rt_busy_blocks_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !rt_busy_n_o |-> !rt_wr_ok);

    // R7
    owner_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!rt_busy_n_o && !mode_slave) |=> (!hit || mode_slave || !rt_busy_n_o));

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_slave |-> (lt_busy_n_o && rt_busy_n_o));

    // R9
    slave_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_slave && !lt_busy_n_i) |-> !lt_wr_ok);
endmodule

bind dpca_top dpca_checker u_dpca_checker (
    .clk(clk), .rst(rst), .mode_slave(mode_slave), .hit(hit),
    .lt_busy_n_i(lt_busy_n_i), .rt_busy_n_i(rt_busy_n_i),
    .lt_busy_n_o(lt_busy_n_o), .rt_busy_n_o(rt_busy_n_o),
    .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok)
);

// File: tb/dpca_top_bench.sv
`timescale 1ns/1ps
module dpca_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_slave = 1'b0;
    logic        lt_cs_n = 1'b1, lt_we_n = 1'b1, rt_cs_n = 1'b1, rt_we_n = 1'b1;
    logic [12:0] lt_addr = '0, rt_addr = '0;
    logic        lt_busy_n_i = 1'b1, rt_busy_n_i = 1'b1;
    logic        lt_busy_n_o, rt_busy_n_o, lt_wr_ok, rt_wr_ok;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dpca_top u_dpca_top (
        .clk(clk), .rst(rst), .mode_slave(mode_slave),
        .lt_cs_n(lt_cs_n), .lt_we_n(lt_we_n), .lt_addr(lt_addr),
        .rt_cs_n(rt_cs_n), .rt_we_n(rt_we_n), .rt_addr(rt_addr),
        .lt_busy_n_i(lt_busy_n_i), .rt_busy_n_i(rt_busy_n_i),
        .lt_busy_n_o(lt_busy_n_o), .rt_busy_n_o(rt_busy_n_o),
        .lt_wr_ok(lt_wr_ok), .rt_wr_ok(rt_wr_ok)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {lt_busy_n,rt_busy_n,lt_wr_ok,rt_wr_ok} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {lt_busy_n_o, rt_busy_n_o, lt_wr_ok, rt_wr_ok};
    endfunction

    // drive at falling edge; result visible at the following falling edge
    task automatic drive(input logic lc, input logic lw, input logic [12:0] la,
                         input logic rc, input logic rw, input logic [12:0] ra);
        lt_cs_n = lc; lt_we_n = lw; lt_addr = la;
        rt_cs_n = rc; rt_we_n = rw; rt_addr = ra;
        @(negedge clk);
    endtask

    task automatic idle_ports();
        drive(1, 1, 13'd0, 1, 1, 13'd0);
        drive(1, 1, 13'd0, 1, 1, 13'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset state", outs(), 4'b1100);
    endtask

    task automatic t_differ();
        idle_ports();
        drive(0, 0, 13'h0A0, 0, 0, 13'h0A1);
        chk("R1 distinct addresses", outs(), 4'b1111);
    endtask

    task automatic t_one_disabled();
        idle_ports();
        drive(1, 0, 13'h123, 0, 0, 13'h123);
        chk("R2 left deselected", outs(), 4'b1101);
        drive(0, 0, 13'h055, 1, 0, 13'h055);
        chk("R2 right deselected", outs(), 4'b1110);
    endtask

    task automatic t_left_first();
        idle_ports();
        drive(0, 0, 13'h1FF, 1, 1, 13'h000);
        drive(0, 0, 13'h1FF, 0, 0, 13'h1FF);
        chk("R3 R6 right later is busy and blocked", outs(), 4'b1010);
    endtask

    task automatic t_right_first();
        idle_ports();
        drive(1, 1, 13'h000, 0, 0, 13'h0777);
        drive(0, 0, 13'h0777, 0, 0, 13'h0777);
        chk("R3 R6 left later is busy and blocked", outs(), 4'b0101);
    endtask

    task automatic t_tie();
        idle_ports();
        drive(0, 0, 13'h1FFE, 0, 0, 13'h1FFE);
        chk("R4 R5 tie goes to left", outs(), 4'b1010);
    endtask

    task automatic t_hold_release();
        idle_ports();
        drive(1, 1, 13'h000, 0, 0, 13'h040);
        drive(0, 0, 13'h040, 0, 0, 13'h040);
        chk("R3 right owns", outs(), 4'b0101);
        // both move together: a fresh tie would favour left, but right must keep it
        drive(0, 0, 13'h009, 0, 0, 13'h009);
        chk("R7 priority held across joint move", outs(), 4'b0101);
        drive(0, 0, 13'h009, 1, 1, 13'h009);
        chk("R8 release after collision ends", outs(), 4'b1110);
    endtask

    task automatic t_slave();
        idle_ports();
        mode_slave = 1'b1;
        drive(0, 0, 13'h0AA, 0, 0, 13'h0AA);
        chk("R9 slave busy outputs high", outs(), 4'b1111);
        lt_busy_n_i = 1'b0;
        #1;
        chk("R9 left external inhibit", outs(), 4'b1101);
        lt_busy_n_i = 1'b1;
        rt_busy_n_i = 1'b0;
        #1;
        chk("R9 right external inhibit", outs(), 4'b1110);
        rt_busy_n_i = 1'b1;
        mode_slave = 1'b0;
        idle_ports();
    endtask

    task automatic t_reset_mid_hold();
        idle_ports();
        drive(0, 0, 13'h011, 1, 1, 13'h000);
        drive(0, 0, 13'h011, 0, 0, 13'h011);
        chk("R3 left owns before reset", outs(), 4'b1010);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset clears hold", outs(), 4'b1100);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_differ();
        t_one_disabled();
        t_left_first();
        t_right_first();
        t_tie();
        t_hold_release();
        t_slave();
        t_reset_mid_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule